// File: doc/BRIEF.md
# Four-bit ALU slice with carry lookahead outputs

The block is a 4-bit arithmetic logic slice. A mode input picks between two families of sixteen functions each, chosen by a 4-bit select code. In logic mode each result bit is a Boolean function of the matching A and B bits alone; no carry moves between bit positions. In arithmetic mode the slice adds two operands derived from A and B, plus the carry input, through a full carry lookahead network. Add, subtract, increment, decrement and doubling all come from this one adder.

For cascading, the slice reports a carry output, a group propagate and a group generate that do not depend on the carry input, and an all-ones flag. With the subtract code and no carry in, the all-ones flag signals that A equals B. Slices chain into wider words by feeding each carry output into the next carry input. A parameter chooses between a purely combinational slice and one that registers all outputs on the clock.

Top module: `alu_slice`

## Requirements
- R1: With i_mode=1, each bit i gives o_f[i] = A[i] ? (B[i] ? S[3] : S[2]) : (B[i] ? ~S[0] : ~S[1]), regardless of i_cin. So S=4'b0011 gives all zeros and S=4'b1100 gives all ones.
- R2: With i_mode=0, o_f is the low 4 bits of X + Y + i_cin. Here X = A | (B & S[0]) | (~B & S[1]) and Y = (A & B & S[3]) | (A & ~B & S[2]), each select bit replicated across the word.
- R3: With i_mode=0, the codes give these results: S=4'b1001 gives A plus B plus i_cin; S=4'b1100 gives A plus A (a shift toward the MSB); S=4'b0000 with i_cin=0 gives A; S=4'b0011 with i_cin=0 gives all ones.
- R4: With i_mode=0 and S=4'b0110, o_f is A minus B minus 1 plus i_cin. When i_cin=1, o_cout is 1 exactly when A >= B (no borrow).
- R5: o_p is 1 exactly when every bit of X is 1. o_g is the carry out of X + Y with no carry in. Neither depends on i_cin, and both follow the same rule in either mode.
- R6: o_cout = o_g | (o_p & i_cin) in both modes. In arithmetic mode this equals bit 4 of X + Y + i_cin.
- R7: o_eq is 1 exactly when all bits of o_f are 1. With i_mode=0, S=4'b0110 and i_cin=0, this means A equals B.
- R8: With OUT_REG=1, all outputs show the result for the inputs present at the previous rising clk edge. An active-low asynchronous rst_n clears every output to 0. With OUT_REG=0, the outputs follow the inputs combinationally.
- R9: Four combinational slices, each feeding o_cout into the next i_cin, form a 16-bit adder (S=4'b1001) and a 16-bit subtractor (S=4'b0110, i_cin=1) whose final carry means no borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register option |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| i_a | input | WIDTH (4) | Operand A |
| i_b | input | WIDTH (4) | Operand B |
| i_sel | input | 4 | Function select S |
| i_mode | input | 1 | 1 = logic functions, 0 = arithmetic functions |
| i_cin | input | 1 | Carry input |
| o_f | output | WIDTH (4) | Function result |
| o_cout | output | 1 | Carry output |
| o_p | output | 1 | Group propagate |
| o_g | output | 1 | Group generate |
| o_eq | output | 1 | Result is all ones |

## Verification
The main function is swept over every combination of operands, select code, mode and carry input. This separates a wrong per-bit term, a wrong lookahead carry at any position, and any leak of the carry input into logic mode or into the group signals. Directed vectors on the named codes tell the add, double, subtract-borrow and equality cases apart at their boundary values (A equal to B, A one below B, full-scale operands). A four-slice chain shows that carries ripple correctly between slices, which a single slice cannot reveal.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   // Select codes whose meaning the checks rely on
   typedef enum logic [3:0] {
      SEL_PASS   = 4'b0000,
      SEL_CONST  = 4'b0011,
      SEL_SUB    = 4'b0110,
      SEL_ADD    = 4'b1001,
      SEL_DOUBLE = 4'b1100
   } sel_code_e;

   localparam int unsigned MAX_WIDTH = 16;

   // Lookahead carry into position n: sum of products, no ripple chain
   function automatic logic lookahead_carry(input logic [31:0] x,
                                            input logic [31:0] y,
                                            input logic        cin,
                                            input int unsigned n);
      logic acc;
      logic term;
      acc = cin;
      for (int k = 0; k < 32; k++)
         if (k < int'(n)) acc = acc & x[k];
      for (int j = 0; j < 32; j++) begin
         if (j < int'(n)) begin
            term = y[j];
            for (int k = 0; k < 32; k++)
               if (k > j && k < int'(n)) term = term & x[k];
            acc = acc | term;
         end
      end
      return acc;
   endfunction

endpackage

// File: rtl/alu_slice_terms.sv
module alu_slice_terms #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] i_a,
   input  logic [WIDTH-1:0] i_b,
   input  logic [3:0]       i_sel,
   output logic [WIDTH-1:0] o_x,
   output logic [WIDTH-1:0] o_y
);

   // Per-bit operand terms; y implies x, so x acts as propagate, y as generate
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign o_x[i] = i_a[i] | (i_b[i] & i_sel[0]) | (~i_b[i] & i_sel[1]);
      assign o_y[i] = i_a[i] & (i_b[i] ? i_sel[3] : i_sel[2]);
   end

endmodule

// File: rtl/alu_slice_carry.sv
module alu_slice_carry #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] i_x,
   input  logic [WIDTH-1:0] i_y,
   input  logic             i_cin,
   output logic [WIDTH:0]   o_c,
   output logic             o_p,
   output logic             o_g
);
   import alu_slice_pkg::*;

   // Each carry built independently as a flat sum of products
   for (genvar i = 0; i <= WIDTH; i++) begin : g_carry
      if (i == 0) begin : g_first
         assign o_c[0] = i_cin;
      end else begin : g_la
         always_comb o_c[i] = lookahead_carry(32'(i_x), 32'(i_y), i_cin, i);
      end
   end

   // Group signals, formed by a separate chain that never sees i_cin
   always_comb begin
      logic gacc;
      gacc = 1'b0;
      for (int j = 0; j < int'(WIDTH); j++)
         gacc = i_y[j] | (i_x[j] & gacc);
      o_g = gacc;
      o_p = &i_x;
   end

endmodule

// File: rtl/alu_slice_result.sv
module alu_slice_result #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] i_x,
   input  logic [WIDTH-1:0] i_y,
   input  logic [WIDTH-1:0] i_c,
   input  logic             i_mode,
   output logic [WIDTH-1:0] o_f,
   output logic             o_eq
);

   // Logic mode: carries held off, each bit is the inverted half sum
   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign o_f[i] = i_mode ? ~(i_x[i] ^ i_y[i]) : (i_x[i] ^ i_y[i] ^ i_c[i]);
   end

   assign o_eq = &o_f;

endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] i_a,
   input  logic [WIDTH-1:0] i_b,
   input  logic [3:0]       i_sel,
   input  logic             i_mode,
   input  logic             i_cin,
   output logic [WIDTH-1:0] o_f,
   output logic             o_cout,
   output logic             o_p,
   output logic             o_g,
   output logic             o_eq
);
   import alu_slice_pkg::*;

   localparam int unsigned OUT_BITS = WIDTH + 4;

   if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("alu_slice: WIDTH must lie in 1..16");
   end

   logic [WIDTH-1:0] x_w, y_w, f_w;
   logic [WIDTH:0]   c_w;
   logic             p_w, g_w, eq_w;

   alu_slice_terms #(.WIDTH(WIDTH)) u_terms (
      .i_a(i_a), .i_b(i_b), .i_sel(i_sel), .o_x(x_w), .o_y(y_w)
   );

   alu_slice_carry #(.WIDTH(WIDTH)) u_carry (
      .i_x(x_w), .i_y(y_w), .i_cin(i_cin), .o_c(c_w), .o_p(p_w), .o_g(g_w)
   );

   alu_slice_result #(.WIDTH(WIDTH)) u_result (
      .i_x(x_w), .i_y(y_w), .i_c(c_w[WIDTH-1:0]), .i_mode(i_mode),
      .o_f(f_w), .o_eq(eq_w)
   );

   logic [OUT_BITS-1:0] core_w;
   assign core_w = {eq_w, g_w, p_w, c_w[WIDTH], f_w};

   if (OUT_REG) begin : g_reg
      logic [OUT_BITS-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= core_w;
      end
      assign {o_eq, o_g, o_p, o_cout, o_f} = q_r;

      p_reg_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ({o_eq, o_g, o_p, o_cout, o_f} == $past(core_w)));
   end else begin : g_comb
      assign {o_eq, o_g, o_p, o_cout, o_f} = core_w;
   end

   // Checks on the combinational core, sampled at the clock
   p_logic_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (i_mode && i_sel == SEL_CONST) |-> (f_w == '0));

   p_logic_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (i_mode && i_sel == SEL_DOUBLE) |-> (&f_w));

   p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!i_mode && i_sel == SEL_ADD) |->
      ({c_w[WIDTH], f_w} == ((WIDTH+1)'(i_a) + (WIDTH+1)'(i_b) + (WIDTH+1)'(i_cin))));

   p_no_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!i_mode && i_sel == SEL_SUB && i_cin) |-> (c_w[WIDTH] == (i_a >= i_b)));

   p_cout_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
      c_w[WIDTH] == (g_w | (p_w & i_cin)));

   p_eq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_eq == (&o_f));

endmodule

// File: tb/alu_slice_bench.sv
module alu_slice_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a, b, sel;
   logic       mode, cin;
   logic [3:0] f;
   logic       cout, p, g, eq;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   alu_slice u_alu_slice (
      .clk(clk), .rst_n(rst_n), .i_a(a), .i_b(b), .i_sel(sel),
      .i_mode(mode), .i_cin(cin), .o_f(f), .o_cout(cout), .o_p(p),
      .o_g(g), .o_eq(eq)
   );

   // Four combinational slices rippling into a 16-bit word (R9)
   logic [15:0] ca, cb, cf;
   logic [3:0]  csel;
   logic        ccin;
   logic [4:0]  cc;
   logic [3:0]  unused_p, unused_g, unused_eq;
   assign cc[0] = ccin;

   for (genvar k = 0; k < 4; k++) begin : g_chain
      alu_slice #(.WIDTH(4), .OUT_REG(1'b0)) u_slice (
         .clk(clk), .rst_n(rst_n), .i_a(ca[4*k +: 4]), .i_b(cb[4*k +: 4]),
         .i_sel(csel), .i_mode(1'b0), .i_cin(cc[k]), .o_f(cf[4*k +: 4]),
         .o_cout(cc[k+1]), .o_p(unused_p[k]), .o_g(unused_g[k]), .o_eq(unused_eq[k])
      );
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference from the requirement text: {eq, g, p, cout, f}
   function automatic logic [7:0] model(input logic [3:0] ma, mb, ms,
                                        input logic mm, mc);
      logic [3:0] x, y, r;
      logic [4:0] s0, s1;
      logic       pp, gg, cc_o;
      x  = ma | (mb & {4{ms[0]}}) | (~mb & {4{ms[1]}});
      y  = (ma & mb & {4{ms[3]}}) | (ma & ~mb & {4{ms[2]}});
      s0 = {1'b0, x} + {1'b0, y};
      s1 = s0 + {4'b0, mc};
      pp = &x;
      gg = s0[4];
      cc_o = gg | (pp & mc);
      if (mm) begin
         for (int i = 0; i < 4; i++)
            r[i] = ma[i] ? (mb[i] ? ms[3] : ms[2]) : (mb[i] ? ~ms[0] : ~ms[1]);
      end else begin
         r = s1[3:0];
      end
      return {&r, gg, pp, cc_o, r};
   endfunction

   task automatic apply(input logic [3:0] ta, tb, ts, input logic tm, tc);
      @(negedge clk);
      a = ta; b = tb; sel = ts; mode = tm; cin = tc;
      @(negedge clk);
   endtask

   task automatic t_reset;
      a = 4'hF; b = 4'hF; sel = 4'hC; mode = 1'b1; cin = 1'b1;
      ca = '0; cb = '0; csel = 4'b1001; ccin = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 reset clears outputs", {27'b0, eq, g, p, cout, f}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_sweep;
      for (int s = 0; s < 16; s++)
         for (int m = 0; m < 2; m++)
            for (int c = 0; c < 2; c++)
               for (int ia = 0; ia < 16; ia++)
                  for (int ib = 0; ib < 16; ib++) begin
                     apply(4'(ia), 4'(ib), 4'(s), 1'(m), 1'(c));
                     chk(m ? "R1 R5 R6 R7 logic sweep" : "R2 R5 R6 R7 arith sweep",
                         {24'b0, eq, g, p, cout, f},
                         {24'b0, model(4'(ia), 4'(ib), 4'(s), 1'(m), 1'(c))});
                  end
   endtask

   task automatic t_named_codes;
      apply(4'hA, 4'h7, 4'b1001, 1'b0, 1'b1);
      chk("R3 add 10+7+1", {27'b0, cout, f}, 32'h12);
      apply(4'hB, 4'h0, 4'b1100, 1'b0, 1'b0);
      chk("R3 double 11", {27'b0, cout, f}, 32'h16);
      apply(4'h9, 4'h5, 4'b0000, 1'b0, 1'b0);
      chk("R3 pass A", {28'b0, f}, 32'h9);
      apply(4'h9, 4'h5, 4'b0011, 1'b0, 1'b0);
      chk("R3 minus one", {28'b0, f}, 32'hF);
      apply(4'h6, 4'h6, 4'b0110, 1'b0, 1'b1);
      chk("R4 equal no borrow", {27'b0, cout, f}, 32'h10);
      apply(4'h5, 4'h6, 4'b0110, 1'b0, 1'b1);
      chk("R4 borrow", {27'b0, cout, f}, 32'h0F);
      apply(4'h6, 4'h6, 4'b0110, 1'b0, 1'b0);
      chk("R7 equal flag", {31'b0, eq}, 32'h1);
      apply(4'h6, 4'h7, 4'b0110, 1'b0, 1'b0);
      chk("R7 unequal flag", {31'b0, eq}, 32'h0);
   endtask

   task automatic t_cin_ignored;
      logic [7:0] first;
      apply(4'h3, 4'h5, 4'b1001, 1'b1, 1'b0);
      first = {eq, g, p, cout, f};
      apply(4'h3, 4'h5, 4'b1001, 1'b1, 1'b1);
      chk("R1 logic result ignores cin", {28'b0, f}, {28'b0, first[3:0]});
      chk("R5 p g ignore cin", {30'b0, p, g}, {30'b0, first[5], first[6]});
   endtask

   task automatic t_latency;
      apply(4'h1, 4'h1, 4'b1001, 1'b0, 1'b0);
      @(negedge clk);
      a = 4'h4; b = 4'h3;
      #2;
      chk("R8 output holds before edge", {28'b0, f}, 32'h2);
      @(negedge clk);
      chk("R8 output after one edge", {28'b0, f}, 32'h7);
      rst_n = 1'b0;
      #1;
      chk("R8 async reset", {27'b0, eq, g, p, cout, f} , 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_cascade;
      logic [16:0] e;
      csel = 4'b1001;
      ca = 16'hFFFF; cb = 16'h0001; ccin = 1'b0;
      @(negedge clk);
      chk("R9 16-bit add full carry", {15'b0, cc[4], cf}, 32'h10000);
      ca = 16'h1234; cb = 16'h5678; ccin = 1'b1;
      @(negedge clk);
      e = 17'h1234 + 17'h5678 + 17'h1;
      chk("R9 16-bit add with cin", {15'b0, cc[4], cf}, {15'b0, e});
      csel = 4'b0110;
      ca = 16'h8000; cb = 16'h7FFF; ccin = 1'b1;
      @(negedge clk);
      chk("R9 16-bit sub no borrow", {15'b0, cc[4], cf}, 32'h10001);
      ca = 16'h0100; cb = 16'h0101;
      @(negedge clk);
      chk("R9 16-bit sub borrow", {15'b0, cc[4], cf}, 32'h0FFFF);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_named_codes();
      t_cin_ignored();
      t_latency();
      t_cascade();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule